// File: doc/BRIEF.md
# Big-Endian Load/Store Data Aligner

This unit sits between a 32-bit register file and a 32-bit big-endian data bus. On a store it moves a byte, halfword, word or one half of a double-word into the bus lanes that the address selects and raises the matching lane write enables. On a load it picks the addressed byte or halfword out of the returned bus word, places it at the low end of the result and extends it with zeros or with its sign bit.

Big-endian lane order applies throughout. Byte offset 0 is the most significant lane, bits 31..24, and a double-word moves as two word transfers with the high-order word at the lower address. The unit also checks alignment and, for byte and halfword stores, checks that the register value fits in the stored size. When either check fails, the unit raises an error flag and drives no lane write enable. Every result is registered and appears one clock after the request.

Top module: `mem_align_unit`

## Requirements
- R1: Byte store (size_i=2'b00) at offset k places wdata_i[7:0] on bus bits [31-8k:24-8k], sets only bus_we_o bit 3-k, and drives the other lanes to zero.
- R2: Halfword store (size_i=2'b01) at offset 0 places wdata_i[15:0] on bits [31:16] with bus_we_o=4'b1100. At offset 2 it places them on bits [15:0] with bus_we_o=4'b0011. The other lanes are zero.
- R3: An odd offset for a halfword, or a non-zero offset for a word or double-word (size_i=2'b10/2'b11), sets align_err_o and forces bus_we_o=0 and load_data_o=0. A byte access never raises the alignment error.
- R4: Byte and halfword stores are range checked. A signed store (signed_i=1) passes only when wdata_i[31:7] (byte) or wdata_i[31:15] (halfword) are all equal. An unsigned store passes only when wdata_i[31:8] or wdata_i[31:16] are all zero. A failing store sets range_err_o and forces bus_we_o=0.
- R5: Word store at offset 0 drives all of wdata_i[31:0] with bus_we_o=4'b1111 and never raises range_err_o.
- R6: Double-word store drives wdata_i[63:32] when dw_part_i=0 (first transfer, lower address) and wdata_i[31:0] when dw_part_i=1, each with bus_we_o=4'b1111.
- R7: Byte load at offset k returns rdata_i[31-8k:24-8k] in load_data_o[7:0]. The upper bits are copies of bit 7 when signed_i=1 and zero when signed_i=0.
- R8: Halfword load at offset 0 or 2 returns rdata_i[31:16] or rdata_i[15:0] in load_data_o[15:0], extended with the sign or with zeros in the same way as R7.
- R9: Loads (is_store_i=0) never assert bus_we_o or range_err_o. Word and double-word loads return rdata_i unchanged.
- R10: Every output updates on the clock edge after the request. valid_o is the request flag delayed by one cycle, and reset drives all outputs to zero.
- R11: A cycle with req_valid_i=0 produces valid_o=0, bus_we_o=0 and both error flags low one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| is_store_i | input | 1 | 1 = store, 0 = load |
| size_i | input | 2 | 00 byte, 01 halfword, 10 word, 11 double-word |
| signed_i | input | 1 | 1 = signed type |
| dw_part_i | input | 1 | Double-word transfer: 0 first (high word), 1 second |
| addr_lo_i | input | 2 | Byte offset within the bus word |
| wdata_i | input | 64 | Register data; high word in [63:32] |
| rdata_i | input | 32 | Bus read data |
| valid_o | output | 1 | Registered result valid |
| bus_wdata_o | output | 32 | Positioned store data |
| bus_we_o | output | 4 | Lane write enables, bit 3 = bits 31..24 |
| load_data_o | output | 32 | Aligned, extended load result |
| align_err_o | output | 1 | Misaligned access |
| range_err_o | output | 1 | Store value outside byte/halfword range |

## Verification
The bench walks a byte through all four offsets in both directions, because a little-endian lane mapping would put offset 0 on bits 7..0 and the error would be plain to see. For the range check it stores values on each side of every limit: 0xFF against 0x100, 0x7F and 0xFFFFFF80 against 0x80, and the halfword equivalents. A check that looks at the wrong bit or swaps the signed and unsigned rules rejects a legal value or lets an illegal one reach the lanes. Misaligned halfword and word accesses must show the flag and leave every write enable low. Double-word stores must put the high word first, and sign extension on loads is tested with both set and clear top bits.

// File: rtl/mau_pkg.sv
package mau_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_DWORD = 2'b11
  } size_e;
endpackage

// File: rtl/mau_store_path.sv
module mau_store_path #(
  parameter  int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int OFS_W  = $clog2(LANES)
) (
  input  mau_pkg::size_e      size_i,
  input  logic [OFS_W-1:0]    ofs_i,
  input  logic                dw_part_i,
  input  logic [2*DATA_W-1:0] src_i,
  output logic [DATA_W-1:0]   wdata_o,
  output logic [LANES-1:0]    we_o
);
  import mau_pkg::*;

  // lane 0 (lowest address) is the most significant byte
  always_comb begin
    unique case (size_i)
      SZ_BYTE: begin
        wdata_o = {src_i[7:0], {(DATA_W-8){1'b0}}} >> (8 * ofs_i);
        we_o    = {1'b1, {(LANES-1){1'b0}}} >> ofs_i;
      end
      SZ_HALF: begin
        wdata_o = {src_i[15:0], {(DATA_W-16){1'b0}}} >> (8 * ofs_i);
        we_o    = {2'b11, {(LANES-2){1'b0}}} >> ofs_i;
      end
      SZ_WORD: begin
        wdata_o = src_i[DATA_W-1:0];
        we_o    = '1;
      end
      default: begin
        wdata_o = dw_part_i ? src_i[DATA_W-1:0] : src_i[2*DATA_W-1:DATA_W];
        we_o    = '1;
      end
    endcase
  end
endmodule

// File: rtl/mau_load_path.sv
module mau_load_path #(
  parameter  int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int OFS_W  = $clog2(LANES)
) (
  input  mau_pkg::size_e    size_i,
  input  logic              signed_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] ldata_o
);
  import mau_pkg::*;

  logic [OFS_W-1:0] half_ofs;
  logic [7:0]       byte_sel;
  logic [15:0]      half_sel;

  assign half_ofs = {ofs_i[OFS_W-1:1], 1'b0};
  assign byte_sel = rdata_i[(DATA_W-8)  - 8*ofs_i    +: 8];
  assign half_sel = rdata_i[(DATA_W-16) - 8*half_ofs +: 16];

  always_comb begin
    unique case (size_i)
      SZ_BYTE: ldata_o = {{(DATA_W-8){signed_i & byte_sel[7]}}, byte_sel};
      SZ_HALF: ldata_o = {{(DATA_W-16){signed_i & half_sel[15]}}, half_sel};
      default: ldata_o = rdata_i;
    endcase
  end
endmodule

// File: rtl/mau_check.sv
module mau_check #(
  parameter  int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int OFS_W  = $clog2(LANES)
) (
  input  mau_pkg::size_e    size_i,
  input  logic              signed_i,
  input  logic              is_store_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [DATA_W-1:7] hi_i,
  output logic              align_err_o,
  output logic              range_err_o
);
  import mau_pkg::*;

  logic byte_fits, half_fits;

  always_comb begin
    if (signed_i) begin
      byte_fits = (&hi_i[DATA_W-1:7])  | ~(|hi_i[DATA_W-1:7]);
      half_fits = (&hi_i[DATA_W-1:15]) | ~(|hi_i[DATA_W-1:15]);
    end else begin
      byte_fits = ~(|hi_i[DATA_W-1:8]);
      half_fits = ~(|hi_i[DATA_W-1:16]);
    end
  end

  always_comb begin
    unique case (size_i)
      SZ_BYTE: begin align_err_o = 1'b0;   range_err_o = is_store_i & ~byte_fits; end
      SZ_HALF: begin align_err_o = ofs_i[0]; range_err_o = is_store_i & ~half_fits; end
      default: begin align_err_o = |ofs_i;  range_err_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/mem_align_unit.sv
module mem_align_unit #(
  parameter  int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int OFS_W  = $clog2(LANES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic                is_store_i,
  input  logic [1:0]          size_i,
  input  logic                signed_i,
  input  logic                dw_part_i,
  input  logic [OFS_W-1:0]    addr_lo_i,
  input  logic [2*DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0]   rdata_i,
  output logic                valid_o,
  output logic [DATA_W-1:0]   bus_wdata_o,
  output logic [LANES-1:0]    bus_we_o,
  output logic [DATA_W-1:0]   load_data_o,
  output logic                align_err_o,
  output logic                range_err_o
);
  import mau_pkg::*;

  size_e             size;
  logic [DATA_W-1:0] st_data, ld_data;
  logic [LANES-1:0]  st_we;
  logic              a_err, r_err;

  assign size = size_e'(size_i);

  mau_store_path #(.DATA_W(DATA_W)) u_store (
    .size_i(size), .ofs_i(addr_lo_i), .dw_part_i(dw_part_i),
    .src_i(wdata_i), .wdata_o(st_data), .we_o(st_we)
  );

  mau_load_path #(.DATA_W(DATA_W)) u_load (
    .size_i(size), .signed_i(signed_i), .ofs_i(addr_lo_i),
    .rdata_i(rdata_i), .ldata_o(ld_data)
  );

  mau_check #(.DATA_W(DATA_W)) u_check (
    .size_i(size), .signed_i(signed_i), .is_store_i(is_store_i),
    .ofs_i(addr_lo_i), .hi_i(wdata_i[DATA_W-1:7]),
    .align_err_o(a_err), .range_err_o(r_err)
  );

  logic st_ok, ld_ok;
  assign st_ok = req_valid_i & is_store_i & ~a_err & ~r_err;
  assign ld_ok = req_valid_i & ~is_store_i & ~a_err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      bus_wdata_o <= '0;
      bus_we_o    <= '0;
      load_data_o <= '0;
      align_err_o <= 1'b0;
      range_err_o <= 1'b0;
    end else begin
      valid_o     <= req_valid_i;
      bus_wdata_o <= (req_valid_i & is_store_i) ? st_data : '0;
      bus_we_o    <= st_ok ? st_we : '0;
      load_data_o <= ld_ok ? ld_data : '0;
      align_err_o <= req_valid_i & a_err;
      range_err_o <= req_valid_i & r_err;
    end
  end

  a_r1_byte_single_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && is_store_i && size_i == 2'b00) |=> ($countones(bus_we_o) <= 1));
  a_r3_misaligned_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && size_i[1] && addr_lo_i != '0) |=> (align_err_o && bus_we_o == '0));
  a_r4_range_blocks_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    range_err_o |-> (bus_we_o == '0));
  a_r5_word_all_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && is_store_i && size_i == 2'b10 && addr_lo_i == '0) |=> (&bus_we_o && !range_err_o));
  a_r9_load_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !is_store_i) |=> (bus_we_o == '0 && !range_err_o));
  a_r10_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> valid_o);
  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!valid_o && bus_we_o == '0 && !align_err_o && !range_err_o));
endmodule

// File: tb/mem_align_unit_test.sv
module mem_align_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, is_store = 1'b0, sgn = 1'b0, dw_part = 1'b0;
  logic [1:0]  size = 2'b00, ofs = 2'b00;
  logic [63:0] wdata = '0;
  logic [31:0] rdata = '0;
  logic        valid;
  logic [31:0] bus_wdata, load_data;
  logic [3:0]  bus_we;
  logic        align_err, range_err;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_align_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .is_store_i(is_store),
    .size_i(size), .signed_i(sgn), .dw_part_i(dw_part), .addr_lo_i(ofs),
    .wdata_i(wdata), .rdata_i(rdata), .valid_o(valid), .bus_wdata_o(bus_wdata),
    .bus_we_o(bus_we), .load_data_o(load_data), .align_err_o(align_err),
    .range_err_o(range_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // drive one request at a falling edge, result is visible at the next falling edge
  task automatic issue(input logic st, input logic [1:0] sz, input logic sg, input logic dp,
                       input logic [1:0] o, input logic [63:0] wd, input logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; is_store = st; size = sz; sgn = sg; dw_part = dp;
    ofs = o; wdata = wd; rdata = rd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 reset valid", 32'(valid), 0);
    chk("R10 reset we", 32'(bus_we), 0);
    chk("R10 reset wdata", bus_wdata, 0);
    chk("R10 reset ldata", load_data, 0);
    chk("R10 reset errs", {30'b0, align_err, range_err}, 0);
  endtask

  task automatic t_store_byte;
    for (int k = 0; k < 4; k++) begin
      issue(1, 2'b00, 0, 0, 2'(k), 64'h0000_0000_0000_00A5, 0);
      chk("R1 byte data", bus_wdata, 32'hA5 << (8 * (3 - k)));
      chk("R1 byte we", 32'(bus_we), 32'(4'b0001 << (3 - k)));
      chk("R10 valid", 32'(valid), 1);
    end
  endtask

  task automatic t_store_half;
    issue(1, 2'b01, 0, 0, 2'd0, 64'h0000_0000_0000_BEEF, 0);
    chk("R2 half@0 data", bus_wdata, 32'hBEEF_0000);
    chk("R2 half@0 we", 32'(bus_we), 32'hC);
    issue(1, 2'b01, 1, 0, 2'd2, 64'h0000_0000_0000_1234, 0);
    chk("R2 half@2 data", bus_wdata, 32'h0000_1234);
    chk("R2 half@2 we", 32'(bus_we), 32'h3);
  endtask

  task automatic t_store_word_dword;
    issue(1, 2'b10, 1, 0, 2'd0, 64'h0000_0000_8765_4321, 0);
    chk("R5 word data", bus_wdata, 32'h8765_4321);
    chk("R5 word we", 32'(bus_we), 32'hF);
    chk("R5 word no range err", 32'(range_err), 0);
    issue(1, 2'b11, 0, 0, 2'd0, 64'hCAFE_F00D_1357_9BDF, 0);
    chk("R6 dword first", bus_wdata, 32'hCAFE_F00D);
    chk("R6 dword first we", 32'(bus_we), 32'hF);
    issue(1, 2'b11, 0, 1, 2'd0, 64'hCAFE_F00D_1357_9BDF, 0);
    chk("R6 dword second", bus_wdata, 32'h1357_9BDF);
  endtask

  task automatic t_align;
    issue(1, 2'b01, 0, 0, 2'd1, 64'h12, 0);
    chk("R3 half@1 err", 32'(align_err), 1);
    chk("R3 half@1 we", 32'(bus_we), 0);
    issue(1, 2'b10, 0, 0, 2'd2, 64'h12, 0);
    chk("R3 word@2 err", 32'(align_err), 1);
    chk("R3 word@2 we", 32'(bus_we), 0);
    issue(0, 2'b11, 0, 0, 2'd3, 0, 32'hFFFF_FFFF);
    chk("R3 dword load@3 err", 32'(align_err), 1);
    chk("R3 dword load@3 data", load_data, 0);
    issue(1, 2'b00, 0, 0, 2'd3, 64'h12, 0);
    chk("R3 byte@3 no err", 32'(align_err), 0);
  endtask

  task automatic t_range;
    issue(1, 2'b00, 0, 0, 0, 64'h0000_00FF, 0); chk("R4 ub 0xFF ok", 32'(range_err), 0);
    issue(1, 2'b00, 0, 0, 0, 64'h0000_0100, 0); chk("R4 ub 0x100 err", 32'(range_err), 1);
    chk("R4 ub err we", 32'(bus_we), 0);
    issue(1, 2'b00, 1, 0, 0, 64'h0000_007F, 0); chk("R4 sb 0x7F ok", 32'(range_err), 0);
    issue(1, 2'b00, 1, 0, 0, 64'hFFFF_FF80, 0); chk("R4 sb -128 ok", 32'(range_err), 0);
    issue(1, 2'b00, 1, 0, 0, 64'h0000_0080, 0); chk("R4 sb 0x80 err", 32'(range_err), 1);
    chk("R4 sb err we", 32'(bus_we), 0);
    issue(1, 2'b01, 0, 0, 0, 64'h0000_FFFF, 0); chk("R4 uh 0xFFFF ok", 32'(range_err), 0);
    issue(1, 2'b01, 0, 0, 0, 64'h0001_0000, 0); chk("R4 uh 0x10000 err", 32'(range_err), 1);
    issue(1, 2'b01, 1, 0, 0, 64'hFFFF_8000, 0); chk("R4 sh -32768 ok", 32'(range_err), 0);
    issue(1, 2'b01, 1, 0, 0, 64'h0000_8000, 0); chk("R4 sh 0x8000 err", 32'(range_err), 1);
  endtask

  task automatic t_load;
    logic [31:0] rd = 32'h81_42_C3_24;
    logic [7:0]  b;
    for (int k = 0; k < 4; k++) begin
      b = rd[31 - 8*k -: 8];
      issue(0, 2'b00, 0, 0, 2'(k), 0, rd);
      chk("R7 ubyte load", load_data, {24'b0, b});
      issue(0, 2'b00, 1, 0, 2'(k), 0, rd);
      chk("R7 sbyte load", load_data, {{24{b[7]}}, b});
      chk("R9 load we", 32'(bus_we), 0);
    end
    issue(0, 2'b01, 1, 0, 2'd0, 0, 32'h8001_7FFE);
    chk("R8 shalf@0", load_data, 32'hFFFF_8001);
    issue(0, 2'b01, 1, 0, 2'd2, 0, 32'h8001_7FFE);
    chk("R8 shalf@2", load_data, 32'h0000_7FFE);
    issue(0, 2'b01, 0, 0, 2'd2, 0, 32'h0000_F00F);
    chk("R8 uhalf@2", load_data, 32'h0000_F00F);
    issue(0, 2'b10, 1, 0, 2'd0, 64'h0000_0100, 32'hDEAD_BEEF);
    chk("R9 word load", load_data, 32'hDEAD_BEEF);
    chk("R9 word load no range err", 32'(range_err), 0);
    issue(0, 2'b11, 0, 1, 2'd0, 0, 32'h0BAD_F00D);
    chk("R9 dword load", load_data, 32'h0BAD_F00D);
  endtask

  task automatic t_idle;
    @(negedge clk);
    req_valid = 1'b0; is_store = 1'b1; size = 2'b10; ofs = 2'd1; wdata = 64'h1FF;
    @(negedge clk);
    chk("R11 idle valid", 32'(valid), 0);
    chk("R11 idle we", 32'(bus_we), 0);
    chk("R11 idle errs", {30'b0, align_err, range_err}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3 + 1);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_store_byte();
    t_store_half();
    t_store_word_dword();
    t_align();
    t_range();
    t_load();
    t_idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule